// File: doc/BRIEF.md
# Length-Framed Command Packet FIFO

This block receives 16-bit command words from an uplink receiver and queues them for host software. Every packet opens with a length word that gives the total number of words in the packet, the length word included. A down-counter is loaded from that word and counts the packet down as it is written, so the block can report each complete packet without software parsing the stream.

The block raises one level-sensitive interrupt for three events: a packet has fully arrived, the queue has filled, or a length word is out of range. Software works through four host registers. A data register pops one word on each read. A status register returns live and sticky flags, and a write of ones clears the sticky flags. A control register flushes the queue and switches packet framing on or off. A mask register selects which sticky flags drive the interrupt.

A length word of zero, or one above the maximum legal length, counts as a length error. After a fill, the queue accepts no further uplink words until software flushes it.

Top module: `cmd_packet_fifo`

## Requirements
- R1: Accepted uplink words leave the queue in arrival order. Each host read of register 0 (data) pops one word. Status bit 0 reads 1 when the queue holds no words, and a data read from an empty queue returns 0.
- R2: With framing on, the first word of a packet loads the down-counter. Every accepted word, the length word included, decrements it. The accepted word that brings the counter to zero sets sticky status bit 1 (packet available), and the next word is taken as a new length.
- R3: With framing on, a length word of 0 or above MAX_LEN (default 256) sets sticky status bit 2 (length error). The word is still stored, and the following word is taken as a new length. A length of exactly MAX_LEN is legal.
- R4: The accepted word that raises occupancy to DEPTH sets sticky status bit 3 (full error). After that, uplink words are dropped until a flush, even after the queue has been read down.
- R5: Writing 1 to control register 2 bit 0 (flush) empties the queue and lifts the write block. Sticky flags are not changed.
- R6: Writing control bit 1 turns framing on and restarts it at a length word. Writing control bit 2 turns framing off, so words are stored with no packet or length flags. Status bit 4 and control readback bit 1 show whether framing is on.
- R7: Writing 1s to status bits 3:1 clears the matching sticky flags, and a set in the same cycle wins over the clear.
- R8: The irq output is the OR of the sticky flags whose mask bit is set in register 3. Mask bit 0 selects packet available, bit 1 selects length error and bit 2 selects full error.
- R9: After reset the queue is empty, every sticky flag is 0, irq is low, framing is on and all mask bits are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Uplink word strobe |
| up_word | input | WORD_W | Uplink command word |
| csr_wr | input | 1 | Host register write strobe |
| csr_rd | input | 1 | Host register read strobe (pops on the data register) |
| csr_addr | input | 2 | Register select: 0 data, 1 status, 2 control, 3 mask |
| csr_wdata | input | 4 | Host write data |
| csr_rdata | output | WORD_W | Host read data for the selected register |
| irq | output | 1 | Command interrupt |

## Verification
Framing is tried with packets of length 1, 3 and MAX_LEN. These show whether the counter fires on exactly the last word, whether the length word is counted, and whether the boundary length is accepted. Length words of 0 and MAX_LEN+1 are each followed by a valid packet, which shows that a bad length still lets the next word open a packet. Other runs restart framing mid-packet, turn it off and feed it words that would otherwise be illegal lengths, and fill the queue to DEPTH and then push further words. Those further words must be missing from the drained data, which separates a true write block from plain overflow protection.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

   localparam int CSR_DW = 4;

   typedef enum logic [1:0] {
      REG_DATA = 2'd0,
      REG_STAT = 2'd1,
      REG_CTRL = 2'd2,
      REG_MASK = 2'd3
   } reg_sel_e;

   // status register bit positions
   localparam int ST_EMPTY = 0;
   localparam int ST_PKT   = 1;
   localparam int ST_LEN   = 2;
   localparam int ST_FULL  = 3;
   localparam int ST_FRAME = 4;

   // control register bit positions
   localparam int CT_FLUSH = 0;
   localparam int CT_ON    = 1;
   localparam int CT_OFF   = 2;

   // event vector, bit 0 = packet, bit 1 = length, bit 2 = full
   typedef struct packed {
      logic full;
      logic len;
      logic pkt;
   } evt_t;

endpackage

// File: rtl/cmdq_store.sv
module cmdq_store #(
   parameter int W     = 16,
   parameter int DEPTH = 512,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic             empty,
   output logic             full,
   output logic [CNT_W-1:0] level
);

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wp, rp, wp_n, rp_n;
   logic [CNT_W-1:0] cnt;
   logic             do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CNT_W'(DEPTH));
   assign level   = cnt;
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rp];

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2_wrap
         assign wp_n = wp + 1'b1;
         assign rp_n = rp + 1'b1;
      end else begin : g_mod_wrap
         assign wp_n = (wp == PTR_W'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_n = (rp == PTR_W'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else if (clr) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (do_push) wp <= wp_n;
         if (do_pop)  rp <= rp_n;
         case ({do_push, do_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_push && !clr) mem[wp] <= din;
   end

   assert_flush_empties_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);

   assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !pop && !clr) |=> full);

endmodule

// File: rtl/cmdq_framer.sv
module cmdq_framer #(
   parameter int W       = 16,
   parameter int MAX_LEN = 256,
   localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         turn_on,
   input  logic         turn_off,
   input  logic         word_acc,
   input  logic [W-1:0] word,
   output logic         pkt_done,
   output logic         len_bad,
   output logic         enabled
);

   logic             in_pkt;
   logic [LEN_W-1:0] left;
   logic             live, bad_len;

   assign live    = word_acc && enabled && !turn_on && !turn_off;
   assign bad_len = (word == '0) || (word > W'(MAX_LEN));

   always_comb begin
      pkt_done = 1'b0;
      len_bad  = 1'b0;
      if (live) begin
         if (!in_pkt) begin
            if (bad_len)                len_bad  = 1'b1;
            else if (word == W'(1))     pkt_done = 1'b1;
         end else if (left == LEN_W'(1)) begin
            pkt_done = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enabled <= 1'b1;
         in_pkt  <= 1'b0;
         left    <= '0;
      end else if (turn_on) begin
         enabled <= 1'b1;
         in_pkt  <= 1'b0;
         left    <= '0;
      end else if (turn_off) begin
         enabled <= 1'b0;
         in_pkt  <= 1'b0;
         left    <= '0;
      end else if (live) begin
         if (!in_pkt) begin
            if (!bad_len && word != W'(1)) begin
               left   <= LEN_W'(word) - 1'b1;
               in_pkt <= 1'b1;
            end
         end else begin
            left <= left - 1'b1;
            if (left == LEN_W'(1)) in_pkt <= 1'b0;
         end
      end
   end

   assert_count_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      in_pkt |-> (left != '0 && left < LEN_W'(MAX_LEN)));

   assert_off_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !enabled |-> !(pkt_done || len_bad));

endmodule

// File: rtl/cmdq_status.sv
module cmdq_status
   import cmdq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  evt_t       set,
   input  evt_t       clr,
   input  logic       mask_wr,
   input  logic [2:0] mask_din,
   output evt_t       sticky,
   output logic [2:0] mask,
   output logic       irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= '0;
         mask   <= 3'b111;
      end else begin
         sticky <= (sticky & ~clr) | set;
         if (mask_wr) mask <= mask_din;
      end
   end

   assign irq = |(sticky & mask);

   assert_set_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      set.pkt |=> sticky.pkt);

   assert_irq_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq) |-> $past(clr != '0 || mask_wr));

endmodule

// File: rtl/cmd_packet_fifo.sv
module cmd_packet_fifo
   import cmdq_pkg::*;
#(
   parameter int WORD_W  = 16,
   parameter int DEPTH   = 512,
   parameter int MAX_LEN = 256,
   localparam int CNT_W  = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              up_valid,
   input  logic [WORD_W-1:0] up_word,
   input  logic              csr_wr,
   input  logic              csr_rd,
   input  logic [1:0]        csr_addr,
   input  logic [CSR_DW-1:0] csr_wdata,
   output logic [WORD_W-1:0] csr_rdata,
   output logic              irq
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (WORD_W < 8 || WORD_W > 32) begin : g_bad_width
         $error("WORD_W must lie in 8..32");
      end
      if (MAX_LEN < 1 || MAX_LEN >= (1 << WORD_W)) begin : g_bad_len
         $error("MAX_LEN must be positive and fit in one word");
      end
   endgenerate

   reg_sel_e          sel;
   logic              flush, fr_on, fr_off, pop, push, fill;
   logic              wr_block;
   logic [WORD_W-1:0] head;
   logic              q_empty, q_full;
   logic [CNT_W-1:0]  q_level;
   logic              pkt_done, len_bad, fr_en;
   evt_t              ev_set, ev_clr, sticky;
   logic [2:0]        mask;

   assign sel    = reg_sel_e'(csr_addr);
   assign flush  = csr_wr && sel == REG_CTRL && csr_wdata[CT_FLUSH];
   assign fr_on  = csr_wr && sel == REG_CTRL && csr_wdata[CT_ON];
   assign fr_off = csr_wr && sel == REG_CTRL && csr_wdata[CT_OFF];
   assign pop    = csr_rd && sel == REG_DATA;
   assign push   = up_valid && !wr_block && !flush;
   assign fill   = push && !(pop && !q_empty) && q_level == CNT_W'(DEPTH - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     wr_block <= 1'b0;
      else if (flush) wr_block <= 1'b0;
      else if (fill)  wr_block <= 1'b1;
   end

   cmdq_store #(.W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (flush),
      .push  (push),
      .din   (up_word),
      .pop   (pop),
      .dout  (head),
      .empty (q_empty),
      .full  (q_full),
      .level (q_level)
   );

   cmdq_framer #(.W(WORD_W), .MAX_LEN(MAX_LEN)) u_framer (
      .clk      (clk),
      .rst_n    (rst_n),
      .turn_on  (fr_on),
      .turn_off (fr_off),
      .word_acc (push),
      .word     (up_word),
      .pkt_done (pkt_done),
      .len_bad  (len_bad),
      .enabled  (fr_en)
   );

   assign ev_set.pkt  = pkt_done;
   assign ev_set.len  = len_bad;
   assign ev_set.full = fill;
   assign ev_clr      = (csr_wr && sel == REG_STAT) ? evt_t'(csr_wdata[3:1]) : '0;

   cmdq_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .set      (ev_set),
      .clr      (ev_clr),
      .mask_wr  (csr_wr && sel == REG_MASK),
      .mask_din (csr_wdata[2:0]),
      .sticky   (sticky),
      .mask     (mask),
      .irq      (irq)
   );

   always_comb begin
      csr_rdata = '0;
      case (sel)
         REG_DATA: csr_rdata = q_empty ? '0 : head;
         REG_STAT: begin
            csr_rdata[ST_EMPTY] = q_empty;
            csr_rdata[ST_PKT]   = sticky.pkt;
            csr_rdata[ST_LEN]   = sticky.len;
            csr_rdata[ST_FULL]  = sticky.full;
            csr_rdata[ST_FRAME] = fr_en;
         end
         REG_CTRL: csr_rdata[CT_ON] = fr_en;
         REG_MASK: csr_rdata[2:0] = mask;
         default:  csr_rdata = '0;
      endcase
   end

   assert_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
      q_full |-> !push);

   assert_blocked_no_growth_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_block && !flush) |=> (q_level <= $past(q_level)));

endmodule

// File: tb/tb_cmd_packet_fifo.sv
module tb_cmd_packet_fifo;
   localparam int CLK_P  = 10;
   localparam int WORD_W = 16;
   localparam int DEPTH  = 512;
   localparam int MAXL   = 256;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              up_valid = 1'b0;
   logic [WORD_W-1:0] up_word = '0;
   logic              csr_wr = 1'b0;
   logic              csr_rd = 1'b0;
   logic [1:0]        csr_addr = 2'd1;
   logic [3:0]        csr_wdata = '0;
   logic [WORD_W-1:0] csr_rdata;
   logic              irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [WORD_W-1:0] exp_q[$];

   always #(CLK_P/2) clk = ~clk;

   cmd_packet_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH), .MAX_LEN(MAXL)) dut (
      .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_word(up_word),
      .csr_wr(csr_wr), .csr_rd(csr_rd), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq(irq));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every data read is compared against the next expected word
   always @(negedge clk) begin
      if (rst_n && csr_rd && csr_addr == 2'd0) begin
         if (exp_q.size() > 0) check("R1 data order", 32'(csr_rdata), 32'(exp_q.pop_front()));
         else                  check("R5 read of empty queue", 32'(csr_rdata), 32'h0);
      end
   end

   task automatic send(input logic [WORD_W-1:0] w, input bit kept);
      up_valid = 1'b1;
      up_word  = w;
      if (kept) exp_q.push_back(w);
      @(posedge clk); #1;
      up_valid = 1'b0;
   endtask

   task automatic csr_write(input logic [1:0] a, input logic [3:0] d);
      csr_wr = 1'b1; csr_addr = a; csr_wdata = d;
      @(posedge clk); #1;
      csr_wr = 1'b0; csr_addr = 2'd1;
   endtask

   task automatic peek_stat(output logic [WORD_W-1:0] st, output logic iv);
      csr_addr = 2'd1;
      @(negedge clk);
      st = csr_rdata;
      iv = irq;
      @(posedge clk); #1;
   endtask

   task automatic pop_one();
      csr_rd = 1'b1; csr_addr = 2'd0;
      @(posedge clk); #1;
      csr_rd = 1'b0; csr_addr = 2'd1;
   endtask

   task automatic drain();
      while (exp_q.size() > 0) pop_one();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [WORD_W-1:0] st;
      logic iv;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R9 reset state
      peek_stat(st, iv);
      check("R9 status after reset", 32'(st), 32'h11);
      check("R9 irq after reset", 32'(iv), 32'h0);
      csr_addr = 2'd3; @(negedge clk);
      check("R9 mask after reset", 32'(csr_rdata), 32'h7);
      @(posedge clk); #1;

      // R2 three-word packet
      send(16'd3, 1); send(16'hA1, 1);
      peek_stat(st, iv);
      check("R2 no packet before last word", 32'(st[1]), 32'h0);
      send(16'hA2, 1);
      peek_stat(st, iv);
      check("R2 packet available", 32'(st[1]), 32'h1);
      check("R8 irq on packet", 32'(iv), 32'h1);
      drain();
      peek_stat(st, iv);
      check("R1 empty after drain", 32'(st[0]), 32'h1);
      csr_write(2'd1, 4'b0010);
      peek_stat(st, iv);
      check("R7 packet flag cleared", 32'(st[1]), 32'h0);
      check("R7 irq low after clear", 32'(iv), 32'h0);

      // R2 length one
      send(16'd1, 1);
      peek_stat(st, iv);
      check("R2 length one completes", 32'(st[1]), 32'h1);
      drain(); csr_write(2'd1, 4'b0010);

      // R3 zero length then valid packet
      send(16'd0, 1);
      peek_stat(st, iv);
      check("R3 zero length error", 32'(st[2]), 32'h1);
      check("R3 zero length no packet", 32'(st[1]), 32'h0);
      send(16'd2, 1); send(16'h55, 1);
      peek_stat(st, iv);
      check("R3 next word opens packet", 32'(st[1]), 32'h1);
      drain(); csr_write(2'd1, 4'b0110);

      // R3 over-long length, then MAX_LEN boundary packet
      send(16'(MAXL + 1), 1);
      peek_stat(st, iv);
      check("R3 over-long length error", 32'(st[2]), 32'h1);
      csr_write(2'd1, 4'b0100);
      send(16'(MAXL), 1);
      for (int i = 1; i < MAXL - 1; i++) send(16'(i), 1);
      peek_stat(st, iv);
      check("R2 boundary no early packet", 32'(st[2:1]), 32'h0);
      send(16'hFFFF, 1);
      peek_stat(st, iv);
      check("R3 MAX_LEN packet legal", 32'(st[2:1]), 32'h1);
      drain(); csr_write(2'd1, 4'b0010);

      // R8 mask
      csr_write(2'd3, 4'b0110);
      send(16'd2, 1); send(16'h11, 1);
      peek_stat(st, iv);
      check("R8 masked flag set", 32'(st[1]), 32'h1);
      check("R8 masked irq low", 32'(iv), 32'h0);
      csr_write(2'd3, 4'b0111);
      peek_stat(st, iv);
      check("R8 unmasked irq high", 32'(iv), 32'h1);
      csr_write(2'd1, 4'b0010); drain();

      // R6 restart mid-packet
      send(16'd5, 1); send(16'h1, 1); send(16'h2, 1);
      csr_write(2'd2, 4'b0010);
      send(16'd2, 1); send(16'h3, 1);
      peek_stat(st, iv);
      check("R6 restart frames new packet", 32'(st[1]), 32'h1);
      csr_write(2'd1, 4'b0010); drain();

      // R6 framing off
      csr_write(2'd2, 4'b0100);
      peek_stat(st, iv);
      check("R6 framing bit off", 32'(st[4]), 32'h0);
      send(16'd0, 1); send(16'd300, 1); send(16'd1, 1);
      peek_stat(st, iv);
      check("R6 no flags when off", 32'(st[3:1]), 32'h0);
      check("R6 irq low when off", 32'(iv), 32'h0);
      drain();
      csr_write(2'd2, 4'b0010);
      csr_addr = 2'd2; @(negedge clk);
      check("R6 control readback on", 32'(csr_rdata), 32'h2);
      @(posedge clk); #1;

      // R5 flush discards
      send(16'd9, 0); send(16'hB, 0); send(16'hC, 0);
      csr_write(2'd2, 4'b0001);
      peek_stat(st, iv);
      check("R5 empty after flush", 32'(st[0]), 32'h1);
      pop_one();
      csr_write(2'd2, 4'b0010);

      // R4 fill and block
      csr_write(2'd2, 4'b0100);
      for (int i = 0; i < DEPTH; i++) send(16'(i ^ 16'h5A00), 1);
      peek_stat(st, iv);
      check("R4 full flag", 32'(st[3]), 32'h1);
      check("R4 irq on full", 32'(iv), 32'h1);
      send(16'hDEAD, 0); send(16'hBEEF, 0);
      drain();
      peek_stat(st, iv);
      check("R4 extra words dropped", 32'(st[0]), 32'h1);
      send(16'h1234, 0);
      peek_stat(st, iv);
      check("R4 still blocked after drain", 32'(st[0]), 32'h1);
      csr_write(2'd2, 4'b0001);
      send(16'h0077, 1);
      peek_stat(st, iv);
      check("R5 writes resume after flush", 32'(st[0]), 32'h0);
      check("R5 flush keeps sticky", 32'(st[3]), 32'h1);
      drain();
      csr_write(2'd1, 4'b1000);
      peek_stat(st, iv);
      check("R7 full flag cleared", 32'(st[3:1]), 32'h0);
      check("R7 irq low at end", 32'(iv), 32'h0);

      finish_run();
   end
endmodule